// File: doc/BRIEF.md
# Operand Bypass Selector

This block sits beside the execute stage of a five-stage in-order pipeline. For each of the two ALU source operands it compares the source register number latched in the decode/execute pipeline register against the destination register numbers of the two instructions ahead of it. The instruction one step ahead sits in the execute/memory register, and the one two steps ahead sits in the memory/writeback register. Each stage's write enable is part of the comparison. The block then picks where the operand should come from: the register file read, the newer ALU result, or the older writeback value.

The block is purely combinational. It emits a 2-bit source code per operand and drives a thin 3-to-1 multiplexer that delivers the chosen 32-bit operand in the same cycle. When one register-to-register ALU instruction feeds the next, the dependent instruction gets its value through this bypass, so the pipeline never has to stall for that case. Stall generation, the register file and the ALU belong to neighbouring blocks.

Top module: `fwd_unit`

## Requirements
- R1: With no qualifying match for an operand, its source code is 2'b00 and the operand output equals the register file value for that operand.
- R2: When the execute/memory destination equals the operand's source register, and that stage writes with a nonzero destination, the code is 2'b01 and the operand equals the execute/memory result.
- R3: When only the memory/writeback stage qualifies (same rules as R2), the code is 2'b10 and the operand equals the writeback value.
- R4: When both stages qualify for the same operand, the execute/memory stage wins (code 2'b01), because it carries the newer value.
- R5: A stage whose write enable is low never causes a bypass from that stage.
- R6: A destination register number of 0 never causes a bypass, even when the source register is also 0.
- R7: Operand A and operand B are resolved independently; each has its own code and output, and A's inputs do not affect B's result.
- R8: The code 2'b11 is never produced.
- R9: Outputs depend only on the present inputs, with no clock delay, so a change of inputs is visible in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| idex_src_a | input | 5 | Source register number for operand A |
| idex_src_b | input | 5 | Source register number for operand B |
| rf_val_a | input | 32 | Register file value read for operand A |
| rf_val_b | input | 32 | Register file value read for operand B |
| exmem_dst | input | 5 | Destination register of the instruction in execute/memory |
| exmem_wen | input | 1 | Register write enable of that instruction |
| exmem_res | input | 32 | ALU result held in execute/memory |
| memwb_dst | input | 5 | Destination register of the instruction in memory/writeback |
| memwb_wen | input | 1 | Register write enable of that instruction |
| memwb_res | input | 32 | Value about to be written back |
| sel_a | output | 2 | Source code for operand A (00 file, 01 newer, 10 older) |
| sel_b | output | 2 | Source code for operand B |
| opnd_a | output | 32 | Selected operand A |
| opnd_b | output | 32 | Selected operand B |

## Verification
The bench targets the case where both stages write the same register that an operand reads. A design with the priority reversed would hand the older writeback value to the ALU and compute with stale data. Register 0 as both source and destination is driven with its write enable high. A design that skips the zero check would bypass a garbage result into a read that must stay at the file's hardwired zero. Stages with write enable low but matching destinations are also driven, which would expose a comparator that ignores the enable. Random traffic over a narrow register range creates frequent collisions between the A and B paths, which would catch any cross-coupling.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

  typedef enum logic [1:0] {
    SRC_FILE  = 2'b00,
    SRC_NEWER = 2'b01,
    SRC_OLDER = 2'b10
  } fwd_src_e;

  // priority encode: newer stage always beats older stage
  function automatic fwd_src_e pick_source(input logic newer_hit, input logic older_hit);
    if (newer_hit)      return SRC_NEWER;
    else if (older_hit) return SRC_OLDER;
    else                return SRC_FILE;
  endfunction

endpackage

// File: rtl/fwd_hit_detect.sv
module fwd_hit_detect #(
  parameter int AW = 5
) (
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] dst,
  input  logic          wen,
  output logic          hit
);

  logic dst_nonzero;
  logic same_reg;

  assign dst_nonzero = |dst;
  assign same_reg    = (src == dst);
  assign hit         = wen & dst_nonzero & same_reg;

  always_comb begin
    // R5: a non-writing stage never bypasses
    p_wen_gate_r5: assert (wen || !hit);
    // R6: destination zero never bypasses
    p_zero_dst_r6: assert ((dst != '0) || !hit);
  end

endmodule

// File: rtl/fwd_pick.sv
module fwd_pick
  import fwd_pkg::*;
(
  input  logic       newer_hit,
  input  logic       older_hit,
  output logic [1:0] sel
);

  fwd_src_e choice;

  always_comb choice = pick_source(newer_hit, older_hit);
  assign sel = choice;

  always_comb begin
    p_sel_legal_r8:      assert (sel != 2'b11);
    p_newer_priority_r4: assert (!newer_hit || sel == 2'b01);
    p_idle_file_r1:      assert (newer_hit || older_hit || sel == 2'b00);
  end

endmodule

// File: rtl/fwd_opnd_mux.sv
module fwd_opnd_mux #(
  parameter int DW = 32
) (
  input  logic [1:0]    sel,
  input  logic [DW-1:0] file_val,
  input  logic [DW-1:0] newer_val,
  input  logic [DW-1:0] older_val,
  output logic [DW-1:0] out_val
);

  always_comb begin
    unique case (sel)
      2'b01:   out_val = newer_val;
      2'b10:   out_val = older_val;
      default: out_val = file_val;
    endcase
  end

  always_comb begin
    p_mux_newer_r2: assert (sel != 2'b01 || out_val == newer_val);
    p_mux_older_r3: assert (sel != 2'b10 || out_val == older_val);
  end

endmodule

// File: rtl/fwd_unit.sv
module fwd_unit #(
  parameter int AW = 5,
  parameter int DW = 32
) (
  input  logic [AW-1:0] idex_src_a,
  input  logic [AW-1:0] idex_src_b,
  input  logic [DW-1:0] rf_val_a,
  input  logic [DW-1:0] rf_val_b,
  input  logic [AW-1:0] exmem_dst,
  input  logic          exmem_wen,
  input  logic [DW-1:0] exmem_res,
  input  logic [AW-1:0] memwb_dst,
  input  logic          memwb_wen,
  input  logic [DW-1:0] memwb_res,
  output logic [1:0]    sel_a,
  output logic [1:0]    sel_b,
  output logic [DW-1:0] opnd_a,
  output logic [DW-1:0] opnd_b
);

  localparam int NSRC = 2;

  logic [AW-1:0] src_arr   [NSRC];
  logic [DW-1:0] file_arr  [NSRC];
  logic [1:0]    sel_arr   [NSRC];
  logic [DW-1:0] out_arr   [NSRC];
  logic          newer_hit [NSRC];
  logic          older_hit [NSRC];

  assign src_arr[0]  = idex_src_a;
  assign src_arr[1]  = idex_src_b;
  assign file_arr[0] = rf_val_a;
  assign file_arr[1] = rf_val_b;

  for (genvar i = 0; i < NSRC; i++) begin : g_opnd
    fwd_hit_detect #(.AW(AW)) u_newer (
      .src(src_arr[i]), .dst(exmem_dst), .wen(exmem_wen), .hit(newer_hit[i])
    );
    fwd_hit_detect #(.AW(AW)) u_older (
      .src(src_arr[i]), .dst(memwb_dst), .wen(memwb_wen), .hit(older_hit[i])
    );
    fwd_pick u_pick (
      .newer_hit(newer_hit[i]), .older_hit(older_hit[i]), .sel(sel_arr[i])
    );
    fwd_opnd_mux #(.DW(DW)) u_mux (
      .sel(sel_arr[i]), .file_val(file_arr[i]), .newer_val(exmem_res),
      .older_val(memwb_res), .out_val(out_arr[i])
    );
  end

  assign sel_a  = sel_arr[0];
  assign sel_b  = sel_arr[1];
  assign opnd_a = out_arr[0];
  assign opnd_b = out_arr[1];

  always_comb begin
    // R7: identical source numbers must resolve identically
    p_same_src_same_sel_r7: assert ((idex_src_a != idex_src_b) || (sel_a == sel_b));
  end

endmodule

// File: tb/fwd_unit_bench.sv
`timescale 1ns/1ps
module fwd_unit_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [4:0]  src_a, src_b, ex_dst, wb_dst;
  logic [31:0] rfa, rfb, ex_res, wb_res;
  logic        ex_wen, wb_wen;
  logic [1:0]  sel_a, sel_b;
  logic [31:0] opnd_a, opnd_b;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  fwd_unit u_fwd_unit (
    .idex_src_a(src_a), .idex_src_b(src_b), .rf_val_a(rfa), .rf_val_b(rfb),
    .exmem_dst(ex_dst), .exmem_wen(ex_wen), .exmem_res(ex_res),
    .memwb_dst(wb_dst), .memwb_wen(wb_wen), .memwb_res(wb_res),
    .sel_a(sel_a), .sel_b(sel_b), .opnd_a(opnd_a), .opnd_b(opnd_b)
  );

  // expected code, written as a lookup over qualification flags
  function automatic logic [1:0] exp_code(input logic [4:0] s);
    bit q_new, q_old;
    q_new = ex_wen && ex_dst != 5'd0 && ex_dst == s;
    q_old = wb_wen && wb_dst != 5'd0 && wb_dst == s;
    return q_new ? 2'b01 : (q_old ? 2'b10 : 2'b00);
  endfunction

  function automatic logic [31:0] exp_val(input logic [1:0] c, input logic [31:0] rf);
    return (c == 2'b01) ? ex_res : (c == 2'b10) ? wb_res : rf;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    logic [1:0] ca, cb;
    ca = exp_code(src_a);
    cb = exp_code(src_b);
    chk(req, {30'd0, sel_a}, {30'd0, ca});
    chk(req, {30'd0, sel_b}, {30'd0, cb});
    chk(req, opnd_a, exp_val(ca, rfa));
    chk(req, opnd_b, exp_val(cb, rfb));
  endtask

  task automatic drive(input logic [4:0] sa, input logic [4:0] sb,
                       input logic [4:0] ed, input logic ew,
                       input logic [4:0] wd, input logic ww);
    @(negedge clk);
    src_a = sa; src_b = sb; ex_dst = ed; ex_wen = ew; wb_dst = wd; wb_wen = ww;
    rfa = $urandom; rfb = $urandom; ex_res = $urandom; wb_res = $urandom;
    #1;
  endtask

  initial begin
    void'($urandom(32'd1234));
    src_a = 0; src_b = 0; ex_dst = 0; wb_dst = 0; ex_wen = 0; wb_wen = 0;
    rfa = 32'h11; rfb = 32'h22; ex_res = 32'h33; wb_res = 32'h44;
    #1;
    // R1: idle state selects the file
    chk("R1", {30'd0, sel_a}, 32'd0);
    chk("R1", opnd_a, 32'h11);
    repeat (2) @(negedge clk);
    rst = 1'b0;

    drive(5'd3, 5'd4, 5'd7, 1, 5'd8, 1); check_all("R1");
    drive(5'd3, 5'd4, 5'd3, 1, 5'd8, 1); check_all("R2");
    chk("R2", {30'd0, sel_a}, 32'd1);
    drive(5'd3, 5'd9, 5'd7, 1, 5'd9, 1); check_all("R3");
    chk("R3", {30'd0, sel_b}, 32'd2);
    drive(5'd5, 5'd5, 5'd5, 1, 5'd5, 1); check_all("R4");
    chk("R4", opnd_a, ex_res);
    drive(5'd6, 5'd6, 5'd6, 0, 5'd6, 1); check_all("R5");
    chk("R5", {30'd0, sel_a}, 32'd2);
    drive(5'd6, 5'd6, 5'd6, 0, 5'd6, 0); check_all("R5");
    chk("R5", opnd_b, rfb);
    drive(5'd0, 5'd0, 5'd0, 1, 5'd0, 1); check_all("R6");
    chk("R6", opnd_a, rfa);
    drive(5'd0, 5'd2, 5'd0, 1, 5'd2, 1); check_all("R6");
    drive(5'd1, 5'd2, 5'd1, 1, 5'd2, 1); check_all("R7");
    chk("R7", {30'd0, sel_b}, 32'd2);
    // R9: change inputs mid-cycle, result visible without an edge
    ex_dst = 5'd2; #0.5;
    chk("R9", {30'd0, sel_b}, 32'd1);

    for (int i = 0; i < 3000; i++) begin
      drive(5'($urandom_range(0, 3)), 5'($urandom_range(0, 3)),
            5'($urandom_range(0, 3)), 1'($urandom),
            5'($urandom_range(0, 3)), 1'($urandom));
      check_all("R7");
      chk("R8", {31'd0, sel_a == 2'b11 || sel_b == 2'b11}, 32'd0);
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule